// File: doc/BRIEF.md
# Cascaded Serial DAC Frame Writer

This block is the host side of a three-wire link to one or more serial-input 6-bit DACs that are daisy-chained, each device's serial output feeding the next device's data input. The host loads a parallel array of codes (one word per channel per device) and pulses `start`. The block then drives an active-low enable, a shift clock that idles high, and a data line. Every timing minimum is a parameter counted in system clock cycles.

The receiving devices shift data in on the falling clock edge and latch it when the enable returns high. The last word shifted in lands in a device's first channel, and the first words shifted in travel to the far end of the chain. For that reason the block sends the highest channel of the last device first and channel 0 of device 0 last, most significant bit first. A frame has one clock pulse per bit, which is 6 pulses per channel per device.

`busy` covers the whole frame. A one-cycle `done` pulse follows the rise of the enable. A `start` that arrives while `busy` is high is dropped.

Top module: `dac_chain_writer`

## Requirements
- R1: Each word goes out most significant bit first. The word for device d, channel c (both counted from 0) sits at `codes[(d*NUM_CH+c)*WORD_W +: WORD_W]`.
- R2: Words go out in descending order: device NUM_DEV-1 channel NUM_CH-1 first, then descending channel within a device, then the next lower device, ending with device 0 channel 0.
- R3: A frame contains exactly NUM_DEV*NUM_CH*WORD_W falling edges of `ser_clk`.
- R4: Every high phase of `ser_clk` between two pulses of a frame lasts max(T_HIGH, T_DSETUP) cycles.
- R5: Every low phase of `ser_clk` lasts max(T_LOW, T_DHOLD) cycles.
- R6: `ser_en_n` falls while `ser_clk` is high, exactly max(T_HIGH, T_DSETUP, T_ENSETUP) cycles before the first falling clock edge.
- R7: `ser_en_n` rises exactly T_ENHOLD cycles after the final rising clock edge, and it changes only while `ser_clk` is high.
- R8: `ser_data` changes only at the start of a frame or together with a rising clock edge. It is therefore stable for at least T_DSETUP cycles before each falling edge and at least T_DHOLD cycles after it.
- R9: `done` is high for exactly one cycle, the cycle after `ser_en_n` rises, and `busy` is low in that cycle.
- R10: `busy` rises the cycle after an accepted `start` and stays high while `ser_en_n` is low. A `start` seen while `busy` is high changes neither the frame nor the data sent.
- R11: After reset and between frames, `ser_en_n` and `ser_clk` are high and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame; ignored while busy |
| codes | input | NUM_DEV*NUM_CH*WORD_W | Channel codes, captured at start |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse after the enable rises |
| ser_data | output | 1 | Serial data to the first device |
| ser_clk | output | 1 | Shift clock, idles high |
| ser_en_n | output | 1 | Active-low load enable |

## Verification
The bench builds a chain of two devices with four channels each, so a frame is 48 bits. Errors in device order and channel order both show up in that configuration. The timing parameters are chosen so that a different minimum wins in each phase: data setup outranks clock high time, enable setup outranks both of them, and clock low time outranks data hold. A design that ignored any one of these maxima would produce a wrong phase length. Random codes and directed single-channel patterns exercise the bit ordering, and a `start` pulse in the middle of a frame checks that a start is dropped while busy.

// File: rtl/dac_chain_pkg.sv
package dac_chain_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LOW,
    ST_TAIL,
    ST_FIN
  } wr_state_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dac_chain_down_count.sv
module dac_chain_down_count #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          zero
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (dec && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/dac_chain_shifter.sv
module dac_chain_shifter #(
  parameter int LEN = 36
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [LEN-1:0] load_val,
  input  logic           shift,
  output logic           msb
);

  logic [LEN-1:0] sreg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_q <= '0;
    end else if (load) begin
      sreg_q <= load_val;
    end else if (shift) begin
      sreg_q <= {sreg_q[LEN-2:0], 1'b0};
    end
  end

  assign msb = sreg_q[LEN-1];

endmodule

// File: rtl/dac_chain_writer.sv
module dac_chain_writer
  import dac_chain_pkg::*;
#(
  parameter int WORD_W    = 6,
  parameter int NUM_CH    = 6,
  parameter int NUM_DEV   = 1,
  parameter int T_HIGH    = 2,
  parameter int T_LOW     = 5,
  parameter int T_DSETUP  = 1,
  parameter int T_DHOLD   = 5,
  parameter int T_ENSETUP = 5,
  parameter int T_ENHOLD  = 5
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               start,
  input  logic [NUM_DEV*NUM_CH*WORD_W-1:0]   codes,
  output logic                               busy,
  output logic                               done,
  output logic                               ser_data,
  output logic                               ser_clk,
  output logic                               ser_en_n
);

  localparam int TOTAL_BITS = NUM_DEV * NUM_CH * WORD_W;
  localparam int LEAD_CYC   = max2(T_HIGH, T_DSETUP);
  localparam int FIRST_CYC  = max2(LEAD_CYC, T_ENSETUP);
  localparam int LOW_CYC    = max2(T_LOW, T_DHOLD);
  localparam int T_MAX      = max2(max2(FIRST_CYC, LOW_CYC), T_ENHOLD);
  localparam int TW         = $clog2(T_MAX) + 1;
  localparam int BW         = $clog2(TOTAL_BITS) + 1;

  wr_state_t state_q;
  logic      sclk_q, en_n_q, busy_q, done_q;

  logic          t_load, t_zero;
  logic [TW-1:0] t_val;
  logic          b_load, b_dec, b_zero;
  logic          s_load, s_shift;

  // phase timer: a state that loads N-1 lasts N cycles
  dac_chain_down_count #(.CW(TW)) u_phase (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val),
    .dec(1'b1), .zero(t_zero)
  );

  // bits remaining after the current one
  dac_chain_down_count #(.CW(BW)) u_bits (
    .clk(clk), .rst(rst), .load(b_load), .load_val(BW'(TOTAL_BITS - 1)),
    .dec(b_dec), .zero(b_zero)
  );

  // the flat code vector, MSB first, is already in transmit order
  dac_chain_shifter #(.LEN(TOTAL_BITS)) u_shift (
    .clk(clk), .rst(rst), .load(s_load), .load_val(codes),
    .shift(s_shift), .msb(ser_data)
  );

  always_comb begin
    t_load  = 1'b0;
    t_val   = '0;
    b_load  = 1'b0;
    b_dec   = 1'b0;
    s_load  = 1'b0;
    s_shift = 1'b0;
    case (state_q)
      ST_IDLE: if (start) begin
        t_load = 1'b1;
        t_val  = TW'(FIRST_CYC - 1);
        b_load = 1'b1;
        s_load = 1'b1;
      end
      ST_LEAD: if (t_zero) begin
        t_load = 1'b1;
        t_val  = TW'(LOW_CYC - 1);
      end
      ST_LOW: if (t_zero) begin
        t_load = 1'b1;
        if (b_zero) begin
          t_val = TW'(T_ENHOLD - 1);
        end else begin
          t_val   = TW'(LEAD_CYC - 1);
          b_dec   = 1'b1;
          s_shift = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      sclk_q  <= 1'b1;
      en_n_q  <= 1'b1;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_LEAD;
          en_n_q  <= 1'b0;
          busy_q  <= 1'b1;
        end
        ST_LEAD: if (t_zero) begin
          sclk_q  <= 1'b0;
          state_q <= ST_LOW;
        end
        ST_LOW: if (t_zero) begin
          sclk_q  <= 1'b1;
          state_q <= b_zero ? ST_TAIL : ST_LEAD;
        end
        ST_TAIL: if (t_zero) begin
          en_n_q  <= 1'b1;
          state_q <= ST_FIN;
        end
        ST_FIN: begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign ser_clk  = sclk_q;
  assign ser_en_n = en_n_q;

  AST_IDLE_CLK_HIGH: assert property (@(posedge clk) disable iff (rst)
    ser_en_n |-> ser_clk) else $error("clock low with enable inactive"); // R11

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done wider than one cycle"); // R9

  AST_DONE_AFTER_EN: assert property (@(posedge clk) disable iff (rst)
    done |-> (ser_en_n && $past(ser_en_n) && !$past(ser_en_n, 2) && !busy))
    else $error("done not one cycle after enable rise"); // R9

  AST_DATA_STILL_LOW: assert property (@(posedge clk) disable iff (rst)
    (!ser_clk && $past(!ser_clk)) |-> $stable(ser_data))
    else $error("data moved during low phase"); // R8

  AST_EN_CHANGES_CLK_HIGH: assert property (@(posedge clk) disable iff (rst)
    (ser_en_n != $past(ser_en_n)) |-> (ser_clk && $past(ser_clk)))
    else $error("enable moved near clock low"); // R7

  AST_BUSY_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    !ser_en_n |-> busy) else $error("enable low while not busy"); // R10

endmodule

// File: tb/dac_chain_writer_tb.sv
module dac_chain_writer_tb_top;

  localparam int WW = 6, NCH = 4, NDEV = 2;
  localparam int TH = 2, TL = 4, TDS = 3, TDH = 1, TES = 5, TEH = 3;
  localparam int TOTAL = NDEV * NCH * WW;
  localparam int LEAD  = (TH > TDS) ? TH : TDS;
  localparam int FIRST = (LEAD > TES) ? LEAD : TES;
  localparam int LOWC  = (TL > TDH) ? TL : TDH;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [TOTAL-1:0] codes = '0;
  logic busy, done, ser_data, ser_clk, ser_en_n;

  dac_chain_writer #(.WORD_W(WW), .NUM_CH(NCH), .NUM_DEV(NDEV), .T_HIGH(TH),
    .T_LOW(TL), .T_DSETUP(TDS), .T_DHOLD(TDH), .T_ENSETUP(TES), .T_ENHOLD(TEH)
  ) dut_i (
    .clk(clk), .rst(rst), .start(start), .codes(codes), .busy(busy),
    .done(done), .ser_data(ser_data), .ser_clk(ser_clk), .ser_en_n(ser_en_n)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [TOTAL-1:0] expect_stream(input logic [TOTAL-1:0] c);
    logic [TOTAL-1:0] r;
    int pos;
    r = '0;
    pos = TOTAL - 1;
    for (int d = NDEV - 1; d >= 0; d--)
      for (int ch = NCH - 1; ch >= 0; ch--)
        for (int b = WW - 1; b >= 0; b--) begin
          r[pos] = c[(d*NCH + ch)*WW + b];
          pos--;
        end
    return r;
  endfunction

  // monitor state
  logic [TOTAL-1:0] got = '0, exp_stream = '0;
  logic p_en = 1'b1, p_clk = 1'b1, p_dat = 1'b0;
  int ph = 0, en_cnt = 0, dcnt = 0, bidx = 0, frames = 0, dones = 0;
  bit first = 1'b0, done_due = 1'b0;

  always @(negedge clk) begin
    if (rst) begin
      p_en = ser_en_n; p_clk = ser_clk; p_dat = ser_data;
      ph = 0; en_cnt = 0; dcnt = 0; done_due = 1'b0;
    end else begin
      automatic bit en_fell = p_en && !ser_en_n;
      automatic bit en_rose = !p_en && ser_en_n;
      automatic bit s_fell  = p_clk && !ser_clk;
      automatic bit s_rose  = !p_clk && ser_clk;
      automatic bit d_chg   = (p_dat != ser_data);
      if (done_due) begin
        check(done == 1'b1, "R9", "done after enable rise", done, 1);
        check(busy == 1'b0, "R9", "busy during done", busy, 0);
        done_due = 1'b0;
        dones++;
      end else if (done) begin
        check(1'b0, "R9", "stray done", 1, 0);
      end
      if (s_fell) begin
        if (first) begin
          check(en_cnt == FIRST, "R6", "enable to first fall", en_cnt, FIRST);
          first = 1'b0;
        end else begin
          check(ph == LEAD, "R4", "high phase", ph, LEAD);
        end
        check(dcnt >= TDS, "R8", "data setup", dcnt, TDS);
        if (bidx < TOTAL) got[TOTAL-1-bidx] = ser_data;
        bidx++;
      end
      if (s_rose) check(ph == LOWC, "R5", "low phase", ph, LOWC);
      if (d_chg && !en_fell)
        check(s_rose, "R8", "data change without clock rise", 0, 1);
      if (en_fell) begin
        check(p_clk == 1'b1, "R11", "clock high at enable fall", p_clk, 1);
        en_cnt = 1; first = 1'b1; bidx = 0; frames++;
      end else begin
        en_cnt++;
      end
      if (en_rose) begin
        check(bidx == TOTAL, "R3", "falling edges per frame", bidx, TOTAL);
        check(ph == TEH, "R7", "enable hold", ph, TEH);
        check(got == exp_stream, "R1/R2", "serial stream", got, exp_stream);
        done_due = 1'b1;
      end
      if (s_fell || s_rose) ph = 1; else ph++;
      if (d_chg) dcnt = 1; else dcnt++;
      p_en = ser_en_n; p_clk = ser_clk; p_dat = ser_data;
    end
  end

  task automatic send(input logic [TOTAL-1:0] v, input bit poke);
    int f0, d0, guard;
    while (busy) @(negedge clk);
    codes = v;
    exp_stream = expect_stream(v);
    f0 = frames;
    d0 = dones;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R10", "busy after start", busy, 1);
    if (poke) begin
      repeat (20) @(negedge clk);
      codes = ~v;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (dones == d0 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    check(dones == d0 + 1, "R9", "frame completed", dones - d0, 1);
    check(frames == f0 + 1, "R10", "frames per start", frames - f0, 1);
    repeat (3) @(negedge clk);
    check(ser_en_n && ser_clk && !busy && !done, "R11", "idle outputs",
          {ser_en_n, ser_clk, busy, done}, 4'b1100);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [TOTAL-1:0] v;
    void'($urandom(32'd1357));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(ser_en_n && ser_clk && !busy && !done, "R11", "reset outputs",
          {ser_en_n, ser_clk, busy, done}, 4'b1100);
    send('0, 1'b0);
    send('1, 1'b0);
    v = '0; v[WW-1:0] = '1;                  // device 0 channel 0 only: last word
    send(v, 1'b0);
    v = '0; v[TOTAL-1 -: WW] = 6'b100001;    // top device, top channel: first word
    send(v, 1'b0);
    v = '0; v[NCH*WW +: WW] = 6'b101101;     // device 1 channel 0
    send(v, 1'b1);
    for (int i = 0; i < 8; i++) begin
      v = TOTAL'({$urandom(), $urandom()});
      send(v, (i % 3) == 0);
    end
    summary();
    $finish;
  end

endmodule